// File: doc/BRIEF.md
# ADC Acquisition Sequencer

The block is the host-side controller for a 12-bit serial analog-to-digital converter. The converter runs in hardware-triggered sampling mode. The block is an SPI master. After reset it brings the converter up, then loops through its analog channels without software help. Each result comes out on a parallel port with a one-clock strobe and the number of the channel that was measured.

Each cycle of the loop has four steps. The block sends a command word that names a channel. It drives the separate conversion-start pin low for a timed window, which is the sampling period. It waits for the converter's active-low interrupt pin. It then runs one frame that reads the 12-bit result and, in the same frame, sends the command for the next channel. The converter throws away its first conversion after power-up or restart, so the block drops that first result and measures the same channel again. If the interrupt never arrives, the block raises an error flag and repeats the whole bring-up.

The state machine has these states:
- `ST_INIT` and `ST_INIT_WAIT` send the initialisation word.
- `ST_CFG` and `ST_CFG_WAIT` send the configuration word.
- `ST_SEL` and `ST_SEL_WAIT` send the first channel command.
- `ST_ARM` loads the pulse timer.
- `ST_PULSE` holds the start pin low.
- `ST_CONV` waits for the interrupt or the timeout.
- `ST_READ` and `ST_READ_WAIT` run the combined read and next-command frame.

The transitions are:
- `*_WAIT` states move on when the frame engine signals completion.
  - `ST_INIT_WAIT` goes to `ST_CFG`.
  - `ST_CFG_WAIT` goes to `ST_SEL`.
  - `ST_SEL_WAIT` goes to `ST_ARM`.
  - `ST_READ_WAIT` goes to `ST_ARM`.
- `ST_ARM` goes to `ST_PULSE`.
- `ST_PULSE` goes to `ST_CONV` when the pulse timer runs out.
- `ST_CONV` goes to `ST_READ` when the interrupt is seen, or to `ST_INIT` when the timeout runs out.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset the first frame carries 16'hA000. The second frame carries the configuration word: 4'hA in bits 15:12 and the parameter CFG_BITS in bits 11:0.
- R2: Every frame has exactly 16 SCLK periods, most significant bit first. `spi_cs_n` is low only during a frame and goes high between any two frames.
- R3: SCLK idles low. `spi_mosi` changes only while SCLK is low, so the converter captures it on rising edges. `spi_miso` is sampled at each rising edge.
- R4: A channel command has the channel number in bits 15:12 and zeros in bits 11:0. The first frame after configuration selects channel 0. Each read frame carries the command for the next conversion.
- R5: `conv_start_n` is low for exactly START_CLKS clocks, and only while `spi_cs_n` is high. Elaboration fails unless that window is longer than 800 ns at CLK_HZ.
- R6: A read frame starts only after `adc_int_n` has been seen low, following the rising edge of `conv_start_n`.
- R7: `res_data` is bits 15:4 of the word read in. `res_valid` is high for exactly one clock. `res_chan` gives the channel of the completed conversion.
- R8: The first conversion after reset or restart gives no strobe. Its read frame selects channel 0 again, so the first strobed result belongs to channel 0.
- R9: Strobed results step through channels 0, 1, ..., NUM_CH-1 and then wrap to 0.
- R10: If `adc_int_n` stays high for TIMEOUT_CLKS clocks after the pulse ends, `err_timeout` rises and the sequence restarts at R1. The flag stays set until the next strobed result clears it.
- R11: During reset, `spi_cs_n` and `conv_start_n` are high, and `spi_sclk`, `res_valid` and `err_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | output | 1 | Serial clock to the converter, idle low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |
| spi_cs_n | output | 1 | Frame select, active low |
| conv_start_n | output | 1 | Sampling window / conversion start, active low |
| adc_int_n | input | 1 | End-of-conversion interrupt, active low |
| res_valid | output | 1 | One-clock result strobe |
| res_data | output | 12 | Conversion result |
| res_chan | output | CH_W | Channel of the result |
| err_timeout | output | 1 | Interrupt timeout flag, sticky until the next result |

## Verification
The hardest situation to reach from the ports is the interrupt timeout in the middle of a run. It needs a converter that has been configured and is converting but stops answering. The bench's behavioural converter has a switch that suppresses its interrupt, and the bench turns it on after a full round of vectors. The bench then checks that a complete bring-up follows and that the first result is discarded again. To check the discard itself, the model answers the first conversion after each initialisation word with a poison value. Its later results come from the vector table, so a missed discard or a misrouted channel shows up at the result port.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_INIT_WAIT,
        ST_CFG,
        ST_CFG_WAIT,
        ST_SEL,
        ST_SEL_WAIT,
        ST_ARM,
        ST_PULSE,
        ST_CONV,
        ST_READ,
        ST_READ_WAIT
    } seq_state_t;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_LEAD,
        SP_HIGH,
        SP_LOW,
        SP_TAIL
    } spi_phase_t;

    localparam logic [15:0] BRINGUP_WORD = 16'hA000;
    localparam logic [3:0]  CFG_NIBBLE   = 4'hA;

    function automatic logic [15:0] chan_cmd(input logic [3:0] ch);
        return {ch, 12'h000};
    endfunction

endpackage

// File: rtl/adc_countdown.sv
module adc_countdown #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic busy,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(LIMIT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy    = (cnt_q != '0);
    assign expired = (cnt_q == W'(1));

    // R5: a load always starts the full window
    assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (cnt_q == W'(LIMIT)));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_acq_pkg::*;
#(
    parameter int unsigned DIV_HALF = 4,
    parameter int unsigned WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BIT_W = $clog2(WORD_W);

    spi_phase_t        phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] tx_q, rx_q;
    logic              half_end, last_bit;

    assign half_end = (cnt_q == CNT_W'(DIV_HALF - 1));
    assign last_bit = (bit_q == BIT_W'(WORD_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= SP_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            SP_IDLE: if (start)    phase_d = SP_LEAD;
            SP_LEAD: if (half_end) phase_d = SP_HIGH;
            SP_HIGH: if (half_end) phase_d = last_bit ? SP_TAIL : SP_LOW;
            SP_LOW:  if (half_end) phase_d = SP_HIGH;
            SP_TAIL: if (half_end) phase_d = SP_IDLE;
            default:               phase_d = SP_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase_q == SP_IDLE || half_end) cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
            unique case (phase_q)
                SP_IDLE: if (start) begin
                    tx_q  <= tx_word;
                    bit_q <= '0;
                    cs_n  <= 1'b0;
                end
                SP_LEAD, SP_LOW: if (half_end) begin
                    sclk <= 1'b1;
                    rx_q <= {rx_q[WORD_W-2:0], miso};
                end
                SP_HIGH: if (half_end) begin
                    sclk <= 1'b0;
                    if (last_bit) begin
                        cs_n <= 1'b1;
                    end else begin
                        tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
                        bit_q <= bit_q + 1'b1;
                    end
                end
                SP_TAIL: if (half_end) done <= 1'b1;
                default: ;
            endcase
        end
    end

    assign mosi    = tx_q[WORD_W-1];
    assign rx_word = rx_q;

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bit_q == BIT_W'(WORD_W - 1)));

endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
    import adc_acq_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 200_000_000,
    parameter int unsigned     SCLK_HALF    = 4,
    parameter int unsigned     START_CLKS   = 200,
    parameter int unsigned     TIMEOUT_CLKS = 3000,
    parameter int unsigned     NUM_CH       = 4,
    parameter logic [11:0]     CFG_BITS     = 12'h800,
    localparam int             CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            spi_sclk,
    output logic            spi_mosi,
    input  logic            spi_miso,
    output logic            spi_cs_n,
    output logic            conv_start_n,
    input  logic            adc_int_n,
    output logic            res_valid,
    output logic [11:0]     res_data,
    output logic [CH_W-1:0] res_chan,
    output logic            err_timeout
);
    localparam longint unsigned PULSE_NS =
        (longint'(START_CLKS) * 64'd1_000_000_000) / CLK_HZ;

    generate
        if (PULSE_NS <= 800) begin : g_pulse_too_short
            $error("conversion start window must exceed 800 ns");
        end
        if (NUM_CH > 16 || NUM_CH < 1) begin : g_bad_chan_count
            $error("channel count must be 1..16");
        end
    endgenerate

    seq_state_t      state_q, state_d;
    logic [CH_W-1:0] ch_q, ch_inc, ch_next_cmd;
    logic            discard_q;
    logic [1:0]      int_sync_q;
    logic            int_low;

    logic            xfer_start, xfer_done;
    logic [15:0]     xfer_word, rx_word;
    logic            pulse_load, pulse_busy, pulse_exp;
    logic            to_load, to_clear, to_busy, to_exp;

    // two-flop synchroniser on the asynchronous interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_sync_q <= 2'b11;
        else        int_sync_q <= {int_sync_q[0], adc_int_n};
    end
    assign int_low = !int_sync_q[1];

    assign ch_inc      = (ch_q == CH_W'(NUM_CH - 1)) ? '0 : ch_q + 1'b1;
    assign ch_next_cmd = discard_q ? ch_q : ch_inc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:      state_d = ST_INIT_WAIT;
            ST_INIT_WAIT: if (xfer_done) state_d = ST_CFG;
            ST_CFG:       state_d = ST_CFG_WAIT;
            ST_CFG_WAIT:  if (xfer_done) state_d = ST_SEL;
            ST_SEL:       state_d = ST_SEL_WAIT;
            ST_SEL_WAIT:  if (xfer_done) state_d = ST_ARM;
            ST_ARM:       state_d = ST_PULSE;
            ST_PULSE:     if (pulse_exp) state_d = ST_CONV;
            ST_CONV: begin
                if (int_low)     state_d = ST_READ;
                else if (to_exp) state_d = ST_INIT;
            end
            ST_READ:      state_d = ST_READ_WAIT;
            ST_READ_WAIT: if (xfer_done) state_d = ST_ARM;
            default:      state_d = ST_INIT;
        endcase
    end

    // frame launch and word selection
    always_comb begin
        xfer_start = 1'b0;
        xfer_word  = 16'h0000;
        unique case (state_q)
            ST_INIT: begin
                xfer_start = 1'b1;
                xfer_word  = BRINGUP_WORD;
            end
            ST_CFG: begin
                xfer_start = 1'b1;
                xfer_word  = {CFG_NIBBLE, CFG_BITS};
            end
            ST_SEL: begin
                xfer_start = 1'b1;
                xfer_word  = chan_cmd(4'(ch_q));
            end
            ST_READ: begin
                xfer_start = 1'b1;
                xfer_word  = chan_cmd(4'(ch_next_cmd));
            end
            default: ;
        endcase
    end

    assign pulse_load = (state_q == ST_ARM);
    assign to_load    = (state_q == ST_PULSE) && pulse_exp;
    assign to_clear   = (state_q == ST_CONV) && int_low;

    // outputs and channel bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q        <= '0;
            discard_q   <= 1'b1;
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_chan    <= '0;
            err_timeout <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                ST_CFG_WAIT: if (xfer_done) begin
                    ch_q      <= '0;
                    discard_q <= 1'b1;
                end
                ST_CONV: if (!int_low && to_exp) begin
                    err_timeout <= 1'b1;
                    ch_q        <= '0;
                    discard_q   <= 1'b1;
                end
                ST_READ_WAIT: if (xfer_done) begin
                    if (discard_q) begin
                        discard_q <= 1'b0;
                    end else begin
                        res_valid   <= 1'b1;
                        res_data    <= rx_word[15:4];
                        res_chan    <= ch_q;
                        ch_q        <= ch_inc;
                        err_timeout <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    adc_spi_frame #(
        .DIV_HALF (SCLK_HALF),
        .WORD_W   (16)
    ) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .tx_word (xfer_word),
        .rx_word (rx_word),
        .done    (xfer_done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .miso    (spi_miso)
    );

    adc_countdown #(.LIMIT(START_CLKS)) pulse_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pulse_load),
        .clear   (1'b0),
        .busy    (pulse_busy),
        .expired (pulse_exp)
    );

    adc_countdown #(.LIMIT(TIMEOUT_CLKS)) wait_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (to_load),
        .clear   (to_clear),
        .busy    (to_busy),
        .expired (to_exp)
    );

    assign conv_start_n = !pulse_busy;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_no_frame_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start_n |-> spi_cs_n);

    assert_read_after_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> $past(int_low));

    assert_wait_timer_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !int_low) |-> to_busy);

    assert_chan_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan <= CH_W'(NUM_CH - 1)));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (state_q == ST_INIT));

endmodule

// File: tb/adc_acq_seq_tb_top.sv
module adc_acq_seq_tb_top;

    localparam int          START   = 200;
    localparam int          TMO     = 3000;
    localparam int          CONV_T  = 60;
    localparam logic [11:0] CFGB    = 12'h800;

    typedef struct packed {
        logic [11:0] data;
        logic [1:0]  chan;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{12'h000, 2'd0}, '{12'hFFF, 2'd1}, '{12'h800, 2'd2}, '{12'h7FF, 2'd3},
        '{12'h001, 2'd0}, '{12'hFFE, 2'd1}, '{12'hA5A, 2'd2}, '{12'h5A5, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_sclk, spi_mosi, spi_cs_n, conv_start_n;
    logic        spi_miso, adc_int_n;
    logic        res_valid, err_timeout;
    logic [11:0] res_data;
    logic [1:0]  res_chan;

    always #2.5 clk = ~clk;

    adc_acq_seq #(
        .START_CLKS   (START),
        .TIMEOUT_CLKS (TMO),
        .CFG_BITS     (CFGB)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (spi_sclk),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .spi_cs_n     (spi_cs_n),
        .conv_start_n (conv_start_n),
        .adc_int_n    (adc_int_n),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_chan     (res_chan),
        .err_timeout  (err_timeout)
    );

    // behavioural converter
    logic        no_int;
    logic [15:0] wlog [64];
    int          nwords = 0, badbits = 0, mosi_bad = 0, rd_early = 0;
    int          pw_min = 1 << 30, pw_max = 0;
    logic        p_cs, p_sc, p_cv, p_mosi, pending;
    logic [15:0] sh_in, out_sr;
    logic [11:0] conv_res;
    int          bits, cc, conv_cnt, lowcnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            p_cs = 1'b1; p_sc = 1'b0; p_cv = 1'b1; p_mosi = 1'b0;
            pending = 1'b0; bits = 0; cc = 0; lowcnt = 0;
            conv_res = 12'h000; out_sr = 16'h0;
            adc_int_n <= 1'b1;
            spi_miso  <= 1'b0;
        end else begin
            if (p_cs && !spi_cs_n) begin
                bits = 0;
                out_sr = {conv_res, 4'h0};
                spi_miso  <= out_sr[15];
                adc_int_n <= 1'b1;
                if (pending) rd_early++;
            end
            if (!spi_cs_n && !p_sc && spi_sclk) begin
                sh_in = {sh_in[14:0], spi_mosi};
                bits++;
            end
            if (!spi_cs_n && p_sc && !spi_sclk) begin
                out_sr = {out_sr[14:0], 1'b0};
                spi_miso <= out_sr[15];
            end
            if (!spi_cs_n && p_sc && spi_sclk && (spi_mosi != p_mosi)) mosi_bad++;
            if (!p_cs && spi_cs_n) begin
                if (bits != 16) badbits++;
                if (nwords < 64) wlog[nwords] = sh_in;
                nwords++;
                if (sh_in == 16'hA000) cc = 0;
            end
            if (!conv_start_n) lowcnt++;
            if (!p_cv && conv_start_n) begin
                if (lowcnt < pw_min) pw_min = lowcnt;
                if (lowcnt > pw_max) pw_max = lowcnt;
                lowcnt = 0;
                cc++;
                if (cc == 1)                conv_res = 12'hABC;
                else if (cc - 2 < 8)        conv_res = VEC[cc-2].data;
                else                        conv_res = 12'h000;
                if (!no_int) begin
                    pending = 1'b1;
                    conv_cnt = CONV_T;
                end
            end
            if (pending) begin
                conv_cnt--;
                if (conv_cnt == 0) begin
                    pending = 1'b0;
                    adc_int_n <= 1'b0;
                end
            end
            p_cs = spi_cs_n; p_sc = spi_sclk; p_cv = conv_start_n; p_mosi = spi_mosi;
        end
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        int n = 0;
        while (!res_valid && n < 8000) begin
            @(negedge clk);
            n++;
        end
        got = res_valid;
    endtask

    task automatic wait_words(input int target);
        int n = 0;
        while (nwords < target && n < 8000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit got;
        int n0;
        rst_n = 1'b0;
        no_int = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(spi_cs_n == 1'b1,     "R11 cs_n",  32'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0,     "R11 sclk",  32'(spi_sclk), 0);
        chk(conv_start_n == 1'b1, "R11 start", 32'(conv_start_n), 1);
        chk(res_valid == 1'b0,    "R11 valid", 32'(res_valid), 0);
        chk(err_timeout == 1'b0,  "R11 err",   32'(err_timeout), 0);
        rst_n = 1'b1;

        // vector walk: R7, R8 (first valid is VEC[0] not poison), R9
        for (int i = 0; i < 8; i++) begin
            wait_valid(got);
            chk(got, "R7 strobe seen", 32'(got), 1);
            chk(res_data == VEC[i].data, "R7 R8 data", 32'(res_data), 32'(VEC[i].data));
            chk(res_chan == VEC[i].chan, "R9 chan",    32'(res_chan), 32'(VEC[i].chan));
            @(negedge clk);
            chk(res_valid == 1'b0, "R7 one clock", 32'(res_valid), 0);
        end

        // R1 bring-up words
        chk(wlog[0] == 16'hA000,        "R1 init word", 32'(wlog[0]), 32'h A000);
        chk(wlog[1] == {4'hA, CFGB},    "R1 cfg word",  32'(wlog[1]), 32'({4'hA, CFGB}));
        // R4 R8 R9 command words: select 0, re-select 0 on discard, then step
        chk(wlog[2] == 16'h0000, "R4 first select", 32'(wlog[2]), 0);
        for (int k = 3; k < 11; k++) begin
            chk(wlog[k] == {2'b00, 2'((k - 3) % 4), 12'h000}, "R4 R8 next cmd",
                32'(wlog[k]), 32'({2'b00, 2'((k - 3) % 4), 12'h000}));
        end
        // R2 R3 framing and edges
        chk(badbits == 0,  "R2 16 clocks per frame", 32'(badbits), 0);
        chk(mosi_bad == 0, "R3 mosi stable while sclk high", 32'(mosi_bad), 0);
        // R5 R6 pulse width and interrupt wait
        chk(pw_min == START && pw_max == START, "R5 pulse width", 32'(pw_min), 32'(START));
        chk(START * 5 > 800, "R5 over 800ns", 32'(START * 5), 800);
        chk(rd_early == 0, "R6 read before interrupt", 32'(rd_early), 0);

        // R10 timeout and restart
        no_int = 1'b1;
        begin
            int n = 0;
            while (!err_timeout && n < TMO + 3000) begin
                @(negedge clk);
                n++;
            end
        end
        chk(err_timeout == 1'b1, "R10 error raised", 32'(err_timeout), 1);
        n0 = nwords;
        no_int = 1'b0;
        wait_words(n0 + 2);
        chk(wlog[n0] == 16'hA000,       "R10 restart init", 32'(wlog[n0]), 32'hA000);
        chk(wlog[n0+1] == {4'hA, CFGB}, "R10 restart cfg",  32'(wlog[n0+1]), 32'({4'hA, CFGB}));
        chk(err_timeout == 1'b1, "R10 flag sticky", 32'(err_timeout), 1);
        wait_valid(got);
        chk(got && res_data == VEC[0].data, "R8 R10 first after restart", 32'(res_data), 32'(VEC[0].data));
        chk(res_chan == 2'd0, "R8 chan after restart", 32'(res_chan), 0);
        chk(err_timeout == 1'b0, "R10 flag cleared", 32'(err_timeout), 0);

        // R11 reset in mid-run, then R1 again
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && conv_start_n && !res_valid && !err_timeout,
            "R11 mid-run reset", {27'd0, spi_cs_n, spi_sclk, conv_start_n, res_valid, err_timeout}, 32'b10100);
        n0 = nwords;
        rst_n = 1'b1;
        wait_words(n0 + 1);
        chk(wlog[n0] == 16'hA000, "R1 after reset", 32'(wlog[n0]), 32'hA000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule